// File: doc/BRIEF.md
# Buffered Serial Transmitter/Receiver with Register Interface

This block is a byte-oriented asynchronous serial port that software drives through a four-register bus. The transmit side has a one-byte holding register in front of a ten-bit frame shifter. When the transmitter is idle, a byte written to it goes straight into the shifter. When a frame is already in flight, the byte waits in the holding register. The receive side oversamples the incoming line 16 times per bit, rebuilds each byte and places it in a receive data register.

Software tracks progress through three flags: holding register empty, last frame complete and received byte waiting. There is also an overrun indicator. Every flag has its own set and clear rules, and the clear rules follow bus access patterns. One interrupt output combines the three flags, each gated by its own enable. Frames are fixed: one low start bit, eight data bits least significant first, and one high stop bit. The line idles high. One bit lasts 16*(divisor+1) clock cycles.

Register map (two-bit address): 0 is status, 1 is data, 2 is control, 3 is the divisor. Status bits are: 7 holding-empty (read only), 6 frame-complete, 5 byte-waiting, 3 overrun. The other status bits read as 0. Control bits are: 0 transmit enable, 1 receive enable, 5 byte-waiting interrupt enable, 6 frame-complete interrupt enable, 7 holding-empty interrupt enable. Control and divisor reset to 0. Read data is combinational, and a read or write takes effect at the clock edge where the strobe is high.

Top module: `uart_regcore`

## Requirements
- R1: After reset the status register reads 0xC0 (holding-empty and frame-complete set, all else clear), the interrupt output is low and the line output is high.
- R2: A transmitted frame is a low start bit, eight data bits least significant first and a high stop bit, each lasting 16*(divisor+1) clocks; between frames the line is high.
- R3: A data write to an idle transmitter loads the shifter directly, the frame starts at once, and status bit 7 reads 1 immediately after the write.
- R4: A data write while a frame is in flight stores the byte in the holding register and clears status bit 7; when the current frame ends, the byte moves to the shifter with no idle gap and status bit 7 sets again.
- R5: Status bit 6 sets only when a stop bit finishes and no byte is waiting in the holding register; it stays 0 between back-to-back frames.
- R6: Status bit 6 clears on a data write that follows a status read (with no other data write in between), and also when 0 is written to it; writing 1 to it has no effect, and a data write with no status read before it leaves it set.
- R7: The receiver detects a falling edge, confirms the start bit at its middle, samples each data bit at its centre, and on a valid frame loads the byte into the data register and sets status bit 5.
- R8: Status bit 5 clears when the data register is read or when 0 is written to it.
- R9: A frame that completes while status bit 5 is still set overwrites the data register and sets status bit 3; writing 0 to bit 3 clears it.
- R10: A low pulse shorter than half a bit is not taken as a start bit, and a frame whose stop bit samples low is discarded; in both cases status bit 5 stays 0.
- R11: The interrupt output is high exactly when at least one of status bits 7, 6 and 5 is set together with its enable (control bits 7, 6 and 5 respectively).
- R12: With control bit 0 clear, data writes start no frame and leave status bit 7 set; with control bit 1 clear, the receive line is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register select |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (drives read side effects) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the selected register |
| rxIn | input | 1 | Serial receive line |
| txOut | output | 1 | Serial transmit line |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest states to reach are those where the flags depend on the history of bus accesses, not only on the line. One is the frame-complete flag that must survive a data write because no status read came before it. Another is the holding-empty flag that must drop and come back across back-to-back frames. The stimulus reaches the first by writing twice with long silent waits between the writes and no status poll in between. It reaches the second by issuing two data writes on consecutive bus cycles and then checking the flags at the stop-bit centre of the second frame, before that frame has finished. On the receive side, the bench reaches overrun, a truncated start pulse and a low stop bit by shaping the receive line directly, and it sweeps all 256 byte values through the receiver.

// File: rtl/uart_regcore_pkg.sv
package uart_regcore_pkg;
  // strobes from control to datapath for the transmit side
  typedef struct packed {
    logic       holdWrite;
    logic       loadFromBus;
    logic       loadFromHold;
    logic [7:0] byteIn;
  } txCmd_t;

  // events reported by the datapath back to control
  typedef struct packed {
    logic txBusy;
    logic txFrameEnd;
    logic rxDone;
  } dpEvt_t;
endpackage

// File: rtl/uart_regcore_dp.sv
module uart_regcore_dp
  import uart_regcore_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  txCmd_t           cmd,
  input  logic [DIV_W-1:0] divisor,
  input  logic             rxEnable,
  input  logic             rxIn,
  output dpEvt_t           evt,
  output logic             txOut,
  output logic [7:0]       rxByte
);
  localparam int OVS_W  = $clog2(OVS);
  localparam int HALF   = OVS / 2 - 1;
  localparam int FRAME_BITS = 10;

  // oversample tick
  logic [DIV_W-1:0] divCnt;
  logic tick;
  assign tick = (divCnt >= divisor);
  always_ff @(posedge clk) begin
    if (!rstN || tick) divCnt <= '0;
    else               divCnt <= divCnt + 1'b1;
  end

  // transmit shifter
  logic [7:0]       holdReg;
  logic [FRAME_BITS-1:0] txShift;
  logic [OVS_W-1:0] txTick;
  logic [3:0]       txBit;
  logic             txBusy;
  logic             txEnd;

  assign txEnd = txBusy && tick && (txTick == OVS_W'(OVS - 1)) && (txBit == 4'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
      txShift <= '1;
      txTick  <= '0;
      txBit   <= '0;
      txBusy  <= 1'b0;
    end else begin
      if (cmd.holdWrite) holdReg <= cmd.byteIn;
      if (cmd.loadFromBus || cmd.loadFromHold) begin
        txShift <= {1'b1, (cmd.loadFromHold ? holdReg : cmd.byteIn), 1'b0};
        txBusy  <= 1'b1;
        txTick  <= '0;
        txBit   <= '0;
      end else if (txEnd) begin
        txBusy  <= 1'b0;
        txShift <= '1;
      end else if (txBusy && tick) begin
        if (txTick == OVS_W'(OVS - 1)) begin
          txTick  <= '0;
          txBit   <= txBit + 1'b1;
          txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
        end else begin
          txTick <= txTick + 1'b1;
        end
      end
    end
  end
  assign txOut = txShift[0];

  // receive sampler
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;
  rxState_t         rxState;
  logic [1:0]       rxSync;
  logic             rxs;
  logic [OVS_W-1:0] rxTick;
  logic [2:0]       rxBit;
  logic [7:0]       rxShift;
  logic             rxDone;

  assign rxs = rxSync[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSync  <= '1;
      rxState <= RX_IDLE;
      rxTick  <= '0;
      rxBit   <= '0;
      rxShift <= '0;
      rxByte  <= '0;
      rxDone  <= 1'b0;
    end else begin
      rxSync <= {rxSync[0], rxIn};
      rxDone <= 1'b0;
      if (!rxEnable) begin
        rxState <= RX_IDLE;
      end else if (tick) begin
        unique case (rxState)
          RX_IDLE: if (!rxs) begin
            rxState <= RX_START;
            rxTick  <= '0;
          end
          RX_START: begin
            if (rxTick == OVS_W'(HALF)) begin
              rxTick  <= '0;
              rxBit   <= '0;
              rxState <= rxs ? RX_IDLE : RX_DATA;
            end else rxTick <= rxTick + 1'b1;
          end
          RX_DATA: begin
            if (rxTick == OVS_W'(OVS - 1)) begin
              rxTick  <= '0;
              rxShift <= {rxs, rxShift[7:1]};
              rxBit   <= rxBit + 1'b1;
              if (rxBit == 3'd7) rxState <= RX_STOP;
            end else rxTick <= rxTick + 1'b1;
          end
          RX_STOP: begin
            if (rxTick == OVS_W'(OVS - 1)) begin
              if (rxs) begin
                rxByte <= rxShift;
                rxDone <= 1'b1;
              end
              rxState <= RX_IDLE;
            end else rxTick <= rxTick + 1'b1;
          end
          default: rxState <= RX_IDLE;
        endcase
      end
    end
  end

  assign evt.txBusy     = txBusy;
  assign evt.txFrameEnd = txEnd;
  assign evt.rxDone     = rxDone;

  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rstN) !txBusy |-> txOut)
    else $error("R2: line low while transmitter idle");
  a_r2_stop_high: assert property (@(posedge clk) disable iff (!rstN) txEnd |-> txOut)
    else $error("R2: frame ended on a low bit");
  a_r10_stop_seen_high: assert property (@(posedge clk) disable iff (!rstN) rxDone |-> $past(rxs))
    else $error("R10: byte accepted with low stop bit");
endmodule

// File: rtl/uart_regcore_ctrl.sv
module uart_regcore_ctrl
  import uart_regcore_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [7:0]       busWdata,
  input  dpEvt_t           evt,
  input  logic [7:0]       rxByte,
  output txCmd_t           cmd,
  output logic [DIV_W-1:0] divisor,
  output logic             rxEnable,
  output logic [7:0]       busRdata,
  output logic             irq
);
  localparam logic [1:0] A_STAT = 2'd0, A_DATA = 2'd1, A_CTRL = 2'd2, A_DIV = 2'd3;

  logic [7:0] ctlReg;
  logic txEmpty, txDone, rxFull, overrun, statusSeen;
  logic wrData, wrStat, rdData, rdStat, acceptTx, txIdleNow;

  assign wrData   = busWr && (busAddr == A_DATA);
  assign wrStat   = busWr && (busAddr == A_STAT);
  assign rdData   = busRd && (busAddr == A_DATA);
  assign rdStat   = busRd && (busAddr == A_STAT);
  assign acceptTx = wrData && ctlReg[0];
  assign txIdleNow = !evt.txBusy || evt.txFrameEnd;

  always_comb begin
    cmd.byteIn       = busWdata;
    cmd.loadFromHold = evt.txFrameEnd && !txEmpty;
    cmd.loadFromBus  = acceptTx && txIdleNow && txEmpty;
    cmd.holdWrite    = acceptTx && !cmd.loadFromBus;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg     <= '0;
      divisor    <= '0;
      txEmpty    <= 1'b1;
      txDone     <= 1'b1;
      rxFull     <= 1'b0;
      overrun    <= 1'b0;
      statusSeen <= 1'b0;
    end else begin
      if (busWr && busAddr == A_CTRL) ctlReg  <= busWdata;
      if (busWr && busAddr == A_DIV)  divisor <= DIV_W'(busWdata);

      if (cmd.holdWrite)         txEmpty <= 1'b0;
      else if (cmd.loadFromHold) txEmpty <= 1'b1;

      if (evt.txFrameEnd && txEmpty)                             txDone <= 1'b1;
      else if ((wrData && statusSeen) || (wrStat && !busWdata[6])) txDone <= 1'b0;

      if (wrData)      statusSeen <= 1'b0;
      else if (rdStat) statusSeen <= 1'b1;

      if (evt.rxDone)                               rxFull <= 1'b1;
      else if (rdData || (wrStat && !busWdata[5]))  rxFull <= 1'b0;

      if (evt.rxDone && rxFull && !rdData) overrun <= 1'b1;
      else if (wrStat && !busWdata[3])     overrun <= 1'b0;
    end
  end

  assign rxEnable = ctlReg[1];
  assign irq = (txEmpty & ctlReg[7]) | (txDone & ctlReg[6]) | (rxFull & ctlReg[5]);

  always_comb begin
    unique case (busAddr)
      A_STAT:  busRdata = {txEmpty, txDone, rxFull, 1'b0, overrun, 3'b000};
      A_DATA:  busRdata = rxByte;
      A_CTRL:  busRdata = ctlReg;
      default: busRdata = 8'(divisor);
    endcase
  end

  a_r4_hold_needs_busy: assert property (@(posedge clk) disable iff (!rstN) !txEmpty |-> evt.txBusy)
    else $error("R4: byte held while transmitter idle");
  a_r5_done_after_stop: assert property (@(posedge clk) disable iff (!rstN) $rose(txDone) |-> $past(evt.txFrameEnd))
    else $error("R5: complete flag set without frame end");
  a_r7_rx_sets_full: assert property (@(posedge clk) disable iff (!rstN) evt.rxDone |=> rxFull)
    else $error("R7: received byte did not set flag");
  a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rstN) $rose(overrun) |-> $past(rxFull))
    else $error("R9: overrun without waiting byte");
endmodule

// File: rtl/uart_regcore.sv
module uart_regcore
  import uart_regcore_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       rxIn,
  output logic       txOut,
  output logic       irq
);
  txCmd_t           txCmd;
  dpEvt_t           dpEvt;
  logic [DIV_W-1:0] divisor;
  logic             rxEnable;
  logic [7:0]       rxByte;

  uart_regcore_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .evt(dpEvt), .rxByte(rxByte), .cmd(txCmd),
    .divisor(divisor), .rxEnable(rxEnable), .busRdata(busRdata), .irq(irq)
  );

  uart_regcore_dp #(.OVS(OVS), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(txCmd), .divisor(divisor), .rxEnable(rxEnable),
    .rxIn(rxIn), .evt(dpEvt), .txOut(txOut), .rxByte(rxByte)
  );
endmodule

// File: tb/uart_regcore_tb.sv
module uart_regcore_tb;
  logic clk = 0;
  logic rstN = 0;
  logic [1:0] busAddr = 0;
  logic busWr = 0, busRd = 0;
  logic [7:0] busWdata = 0;
  logic [7:0] busRdata;
  logic rxIn = 1;
  logic txOut, irq;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_regcore u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rxIn(rxIn), .txOut(txOut), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk); busWr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; busRd = 1; #1 d = busRdata;
    @(negedge clk); busRd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic decodeTx(output logic [7:0] b, output bit ok);
    int guard = 0;
    ok = 1;
    while (txOut !== 1'b0 && guard < 400) begin @(negedge clk); guard++; end
    if (guard >= 400) ok = 0;
    repeat (8) @(negedge clk);
    if (txOut !== 1'b0) ok = 0;
    for (int k = 0; k < 8; k++) begin
      repeat (16) @(negedge clk);
      b[k] = txOut;
    end
    repeat (16) @(negedge clk);
    if (txOut !== 1'b1) ok = 0;
  endtask

  task automatic sendRx(input logic [7:0] b, input int stopLen);
    @(negedge clk); rxIn = 0;
    repeat (16) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rxIn = b[k];
      repeat (16) @(negedge clk);
    end
    if (stopLen > 0) begin rxIn = 0; repeat (stopLen) @(negedge clk); end
    rxIn = 1;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d, b1, b2;
    bit ok1, ok2;
    idle(3);
    chk("R1 line idle in reset", txOut, 1);
    rstN = 1;
    rd(0, s); chk("R1 status after reset", s, 8'hC0);
    chk("R1 irq after reset", irq, 0);
    wr(3, 8'h00);

    // R12: transmitter disabled
    wr(2, 8'h02);
    wr(1, 8'h55);
    begin
      int lows = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (txOut !== 1'b1) lows++; end
      chk("R12 no frame while tx disabled", lows, 0);
    end
    rd(0, s); chk("R12 empty flag kept", s[7], 1);
    wr(2, 8'h03);

    // R2/R3/R5/R6 single frames over several byte values
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 5) & 255);
      rd(0, s);
      wr(1, v);
      rd(0, s);
      chk("R3 empty flag stays set on idle write", s[7], 1);
      chk("R6 complete cleared by read then write", s[6], 0);
      decodeTx(b1, ok1);
      chk("R2 frame framing", ok1, 1);
      chk("R2 frame data", b1, v);
      idle(20);
      rd(0, s); chk("R5 complete after stop", s[6], 1);
    end

    // R4/R5 back-to-back
    rd(0, s);
    wr(1, 8'h3C);
    wr(1, 8'hA7);
    rd(0, s); chk("R4 empty flag cleared by held byte", s[7], 0);
    decodeTx(b1, ok1);
    decodeTx(b2, ok2);
    chk("R4 first frame", {ok1, b1}, {1'b1, 8'h3C});
    chk("R4 second frame follows", {ok2, b2}, {1'b1, 8'hA7});
    rd(0, s);
    chk("R4 empty set after transfer", s[7], 1);
    chk("R5 complete low mid second frame", s[6], 0);
    idle(20);
    rd(0, s); chk("R5 complete after last frame", s[6], 1);

    // R6 write without prior status read
    wr(1, 8'h11);
    idle(200);
    wr(1, 8'h22);
    idle(200);
    rd(0, s); chk("R6 complete kept without status read", s[6], 1);
    wr(0, 8'hE8);
    rd(0, s); chk("R6 writing one keeps complete", s[6], 1);
    wr(0, 8'h00);
    rd(0, s);
    chk("R6 writing zero clears complete", s[6], 0);
    chk("R6 empty flag is read only", s[7], 1);

    // R7/R8 exhaustive receive sweep
    for (int v = 0; v < 256; v++) begin
      sendRx(8'(v), 0);
      rd(0, s); chk("R7 byte waiting set", s[5], 1);
      rd(1, d); chk("R7 received byte", d, v);
      rd(0, s); chk("R8 data read clears waiting", s[5], 0);
    end
    sendRx(8'h81, 0);
    wr(0, 8'hC0);
    rd(0, s); chk("R8 write zero clears waiting", s[5], 0);

    // R9 overrun
    sendRx(8'h11, 0);
    sendRx(8'h22, 0);
    rd(0, s); chk("R9 overrun set", s[3], 1);
    chk("R9 waiting still set", s[5], 1);
    rd(1, d); chk("R9 newest byte kept", d, 8'h22);
    wr(0, 8'hF0);
    rd(0, s); chk("R9 overrun cleared", s[3], 0);

    // R10 glitch and bad stop bit
    @(negedge clk); rxIn = 0; idle(4); rxIn = 1; idle(200);
    rd(0, s); chk("R10 short pulse ignored", s[5], 0);
    sendRx(8'h5A, 12);
    idle(40);
    rd(0, s); chk("R10 low stop discarded", s[5], 0);

    // R12 receiver disabled
    wr(2, 8'h01);
    sendRx(8'h5A, 0);
    rd(0, s); chk("R12 rx disabled", s[5], 0);
    wr(2, 8'h03);

    // R11 interrupt combining
    wr(0, 8'h00);
    idle(2); chk("R11 irq all disabled", irq, 0);
    wr(2, 8'h83); idle(1); chk("R11 irq from empty flag", irq, 1);
    wr(2, 8'h23); idle(1); chk("R11 irq waiting disabled source", irq, 0);
    sendRx(8'h99, 0);
    chk("R11 irq from byte waiting", irq, 1);
    rd(1, d); idle(1); chk("R11 irq drops after read", irq, 0);
    wr(2, 8'h43);
    rd(0, s); wr(1, 8'h0F);
    idle(1); chk("R11 irq low while frame runs", irq, 0);
    idle(200); chk("R11 irq from complete flag", irq, 1);
    wr(0, 8'h80); idle(1); chk("R11 irq cleared with flag", irq, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule